// File: doc/BRIEF.md
# Chained Vector Multiply-Add Engine

This block runs a dependent two-step vector sequence: an elementwise product `p[i] = a[i] * b[i]`, then an elementwise sum `r[i] = p[i] + c[i]`. In chained mode each product goes into the adder pipeline in the cycle it leaves the multiplier pipeline. The two operations therefore overlap element by element and share one chime. The run still pays both pipeline start-up latencies once. In unchained mode every product is parked in a local buffer, and the add stream starts only after the last product has arrived. This puts the two operations in separate convoys.

A run begins with a one-cycle start pulse. The pulse carries the vector length and the mode. The block reports which cycles consume multiplier operands and which consume adder operands. Results come out as a stream with a valid flag. A one-cycle done pulse marks the last result, and a cycle counter shows the length of the operation. Integer arithmetic stands in for floating point: the multiplier pipeline is 7 deep and the adder pipeline is 6 deep.

Top module: `vmac_chain`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `res_valid_o`, `mul_take_o` and `add_take_o` are low and `cyc_o` is 0.
- R2: For a run of effective length V, `mul_take_o` is high in exactly the V consecutive cycles that follow the start cycle. In the k-th of those cycles (k from 0) the block consumes `a_i`/`b_i` as element k.
- R3: In chained mode (`chain_i`=1), element k's adder operand `c_i` is consumed 7 cycles after its multiplier operands. Its result `(a*b + c) mod 2^(2*DATA_W)` appears with `res_valid_o` 13 cycles after its multiplier operands.
- R4: In unchained mode (`chain_i`=0), `add_take_o` is high for V cycles starting V+7 cycles after the first multiplier cycle. Results appear 6 cycles after each adder take, so the last result is valid 2V+12 cycles after the first multiplier cycle.
- R5: `done_o` is a one-cycle pulse in the cycle of the last valid result. In that cycle `cyc_o` equals V+13 (chained) or 2V+13 (unchained). It holds that value until the next accepted start.
- R6: A vector length of 0 raises `done_o` in the first cycle after the start cycle, with no valid result, no operand take and `cyc_o` equal to 1.
- R7: A requested length above 64 (MAX_VL) runs as length 64.
- R8: A start pulse while `busy_o` is high is ignored, together with the length and mode driven alongside it. The running sequence keeps its timing and values.
- R9: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| vlen_i | input | 7 | Requested vector length, 0 to 127, saturated at 64 |
| chain_i | input | 1 | 1 = chained, 0 = unchained, sampled with the start |
| a_i | input | 16 | Multiplier operand A of the current element |
| b_i | input | 16 | Multiplier operand B of the current element |
| c_i | input | 16 | Adder operand of the current element |
| mul_take_o | output | 1 | `a_i`/`b_i` consumed this cycle |
| add_take_o | output | 1 | `c_i` consumed this cycle |
| res_valid_o | output | 1 | `res_o` holds a result |
| res_o | output | 32 | Result `a*b + c`, modulo 2^32 |
| done_o | output | 1 | Pulse with the final result |
| busy_o | output | 1 | Sequence in progress |
| cyc_o | output | 8 | Cycles of the current or last operation |

## Verification
Cycle 0 is the first cycle after the start pulse. In cycle k < V, multiplier operands are taken. Chained adder takes fall at k+7 and results at k+13. Unchained adder takes fall at V+7+k and results at V+13+k. `done_o` falls on the last result cycle, and `busy_o` drops one cycle later. The bench drives fresh random operands every cycle and records them by cycle index. It samples every output at the falling edge of each cycle from 0 to two cycles past the end, against windows computed from these offsets. The counter is checked in the done cycle and again two cycles later to confirm that it holds.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vmac_pipe.sv
module vmac_pipe #(
  parameter int X_W    = 16,
  parameter int Y_W    = 16,
  parameter int OUT_W  = 32,
  parameter int DEPTH  = 7,
  parameter bit IS_MUL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  output logic             out_v,
  output logic [OUT_W-1:0] out_d
);
  logic [OUT_W-1:0] op_d;
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] v_d;

  generate
    if (IS_MUL) begin : g_mul
      assign op_d = OUT_W'(x_i) * OUT_W'(y_i);
    end else begin : g_add
      assign op_d = OUT_W'(x_i) + OUT_W'(y_i);
    end
  endgenerate

  always_comb begin
    v_d = {v_q[DEPTH-2:0], in_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_st
      logic [OUT_W-1:0] q;
      logic             en;
      logic [OUT_W-1:0] nxt;
      if (k == 0) begin : g_first
        assign en  = in_v;
        assign nxt = op_d;
      end else begin : g_next
        assign en  = v_q[k-1];
        assign nxt = g_st[k-1].q;
      end
      always_ff @(posedge clk) begin
        if (en) q <= nxt;
      end
    end
  endgenerate

  assign out_v = v_q[DEPTH-1];
  assign out_d = g_st[DEPTH-1].q;
endmodule

// File: rtl/vmac_pbuf.sv
module vmac_pbuf #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/vmac_seq.sv
module vmac_seq
  import vmac_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vlen_i,
  input  logic             chain_i,
  input  logic             mul_out_v,
  input  logic             add_out_v,
  output logic             busy_o,
  output logic             chain_o,
  output logic             mul_issue_o,
  output logic             add_issue_o,
  output logic [IDX_W-1:0] prod_idx_o,
  output logic [IDX_W-1:0] add_idx_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] vl_q, vl_d;
  logic             chain_q, chain_d;
  logic [IDX_W-1:0] mul_cnt_q, mul_cnt_d;
  logic [IDX_W-1:0] prod_cnt_q, prod_cnt_d;
  logic [IDX_W-1:0] add_cnt_q, add_cnt_d;
  logic [IDX_W-1:0] res_cnt_q, res_cnt_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic [IDX_W-1:0] vl_clamp;
  logic             run;
  logic             last;

  always_comb begin
    if (int'(vlen_i) > MAX_VL) vl_clamp = IDX_W'(MAX_VL);
    else                       vl_clamp = IDX_W'(vlen_i);
  end

  assign run         = (state_q == SEQ_RUN);
  assign mul_issue_o = run && (mul_cnt_q < vl_q);
  assign add_issue_o = run && !chain_q && (prod_cnt_q == vl_q) && (add_cnt_q < vl_q);
  assign last        = run && ((vl_q == '0) ||
                               (add_out_v && (res_cnt_q == vl_q - IDX_W'(1))));

  always_comb begin
    state_d    = state_q;
    vl_d       = vl_q;
    chain_d    = chain_q;
    mul_cnt_d  = mul_cnt_q;
    prod_cnt_d = prod_cnt_q;
    add_cnt_d  = add_cnt_q;
    res_cnt_d  = res_cnt_q;
    cyc_d      = cyc_q;
    if (!run) begin
      if (start_i) begin
        state_d    = SEQ_RUN;
        vl_d       = vl_clamp;
        chain_d    = chain_i;
        mul_cnt_d  = '0;
        prod_cnt_d = '0;
        add_cnt_d  = '0;
        res_cnt_d  = '0;
        cyc_d      = CNT_W'(1);
      end
    end else begin
      if (mul_issue_o) mul_cnt_d  = mul_cnt_q + IDX_W'(1);
      if (mul_out_v)   prod_cnt_d = prod_cnt_q + IDX_W'(1);
      if (add_issue_o) add_cnt_d  = add_cnt_q + IDX_W'(1);
      if (add_out_v)   res_cnt_d  = res_cnt_q + IDX_W'(1);
      if (last) state_d = SEQ_IDLE;
      else      cyc_d   = cyc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      vl_q       <= '0;
      chain_q    <= 1'b0;
      mul_cnt_q  <= '0;
      prod_cnt_q <= '0;
      add_cnt_q  <= '0;
      res_cnt_q  <= '0;
      cyc_q      <= '0;
    end else begin
      state_q    <= state_d;
      vl_q       <= vl_d;
      chain_q    <= chain_d;
      mul_cnt_q  <= mul_cnt_d;
      prod_cnt_q <= prod_cnt_d;
      add_cnt_q  <= add_cnt_d;
      res_cnt_q  <= res_cnt_d;
      cyc_q      <= cyc_d;
    end
  end

  assign busy_o     = run;
  assign chain_o    = chain_q;
  assign prod_idx_o = prod_cnt_q;
  assign add_idx_o  = add_cnt_q;
  assign done_o     = last;
  assign cyc_o      = cyc_q;
endmodule

// File: rtl/vmac_chain.sv
module vmac_chain #(
  parameter int DATA_W  = 16,
  parameter int MAX_VL  = 64,
  parameter int MUL_LAT = 7,
  parameter int ADD_LAT = 6,
  parameter int VL_W    = $clog2(MAX_VL + 1),
  parameter int CNT_W   = $clog2(2 * MAX_VL + MUL_LAT + ADD_LAT + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [VL_W-1:0]     vlen_i,
  input  logic                chain_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [DATA_W-1:0]   c_i,
  output logic                mul_take_o,
  output logic                add_take_o,
  output logic                res_valid_o,
  output logic [2*DATA_W-1:0] res_o,
  output logic                done_o,
  output logic                busy_o,
  output logic [CNT_W-1:0]    cyc_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int IDX_W  = $clog2(MAX_VL + 1);
  localparam int AW     = $clog2(MAX_VL);

  logic              chain_q;
  logic              mul_issue;
  logic              add_issue;
  logic [IDX_W-1:0]  prod_idx;
  logic [IDX_W-1:0]  add_idx;
  logic              mul_out_v;
  logic [PROD_W-1:0] mul_out_d;
  logic              add_in_v;
  logic [PROD_W-1:0] add_in_x;
  logic [PROD_W-1:0] buf_rd;
  logic              add_out_v;
  logic [PROD_W-1:0] add_out_d;
  logic              buf_wr_en;

  vmac_seq #(
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .vlen_i      (vlen_i),
    .chain_i     (chain_i),
    .mul_out_v   (mul_out_v),
    .add_out_v   (add_out_v),
    .busy_o      (busy_o),
    .chain_o     (chain_q),
    .mul_issue_o (mul_issue),
    .add_issue_o (add_issue),
    .prod_idx_o  (prod_idx),
    .add_idx_o   (add_idx),
    .done_o      (done_o),
    .cyc_o       (cyc_o)
  );

  vmac_pipe #(
    .X_W    (DATA_W),
    .Y_W    (DATA_W),
    .OUT_W  (PROD_W),
    .DEPTH  (MUL_LAT),
    .IS_MUL (1'b1)
  ) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (mul_issue),
    .x_i   (a_i),
    .y_i   (b_i),
    .out_v (mul_out_v),
    .out_d (mul_out_d)
  );

  assign buf_wr_en = mul_out_v && !chain_q;

  vmac_pbuf #(
    .W     (PROD_W),
    .DEPTH (MAX_VL),
    .AW    (AW)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr_en),
    .wr_addr (prod_idx[AW-1:0]),
    .wr_data (mul_out_d),
    .rd_addr (add_idx[AW-1:0]),
    .rd_data (buf_rd)
  );

  always_comb begin
    if (chain_q) begin
      add_in_v = mul_out_v;
      add_in_x = mul_out_d;
    end else begin
      add_in_v = add_issue;
      add_in_x = buf_rd;
    end
  end

  vmac_pipe #(
    .X_W    (PROD_W),
    .Y_W    (DATA_W),
    .OUT_W  (PROD_W),
    .DEPTH  (ADD_LAT),
    .IS_MUL (1'b0)
  ) u_add (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (add_in_v),
    .x_i   (add_in_x),
    .y_i   (c_i),
    .out_v (add_out_v),
    .out_d (add_out_d)
  );

  assign mul_take_o  = mul_issue;
  assign add_take_o  = add_in_v;
  assign res_valid_o = add_out_v;
  assign res_o       = add_out_d;
endmodule

// File: rtl/vmac_chain_chk.sv
module vmac_chain_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             res_valid_o,
  input logic             mul_take_o,
  input logic             add_take_o,
  input logic [CNT_W-1:0] cyc_o
);
  // R2: multiplier operands are consumed only inside a run
  a_r2_mul_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    mul_take_o |-> busy_o);

  // R3 / R4: adder operands are consumed only inside a run
  a_r3_add_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    add_take_o |-> busy_o);

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: the counter holds while idle with no start
  a_r5_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(cyc_o));

  // R9: busy drops right after done
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R9: busy stays high until done
  a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R8: results appear only inside a run
  a_r8_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> busy_o);
endmodule

bind vmac_chain vmac_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .res_valid_o (res_valid_o),
  .mul_take_o  (mul_take_o),
  .add_take_o  (add_take_o),
  .cyc_o       (cyc_o)
);

// File: tb/sim_vmac_chain.sv
`timescale 1ns/1ps
module sim_vmac_chain;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  vlen_i;
  logic        chain_i;
  logic [15:0] a_i, b_i, c_i;
  logic        mul_take_o, add_take_o, res_valid_o, done_o, busy_o;
  logic [31:0] res_o;
  logic [7:0]  cyc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] da [0:255];
  logic [15:0] db [0:255];
  logic [15:0] dc [0:255];

  vmac_chain u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .chain_i(chain_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .mul_take_o(mul_take_o), .add_take_o(add_take_o),
    .res_valid_o(res_valid_o), .res_o(res_o), .done_o(done_o),
    .busy_o(busy_o), .cyc_o(cyc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  // Reference timing from the requirements: cycle 0 is the first cycle after start.
  task automatic run_op(input int vreq, input bit ch, input int busy_at);
    int v, last, cfirst, rfirst;
    bit e_mul, e_add, e_val;
    logic [31:0] e_res;
    string tg;
    v      = (vreq > 64) ? 64 : vreq;                  // R7
    last   = (v == 0) ? 0 : (ch ? v + 12 : 2 * v + 12);
    cfirst = ch ? 7 : v + 7;
    rfirst = ch ? 13 : v + 13;
    tg     = ch ? "R3" : "R4";
    @(negedge clk);
    start_i = 1'b1; vlen_i = 7'(vreq); chain_i = ch;
    for (int t = 0; t <= last + 2; t++) begin
      @(negedge clk);
      e_mul = (t < v);
      e_add = (t >= cfirst) && (t < cfirst + v);
      e_val = (t >= rfirst) && (t < rfirst + v);
      check(mul_take_o == e_mul, "R2 mul_take", mul_take_o, e_mul);
      check(add_take_o == e_add, {tg, " add_take"}, add_take_o, e_add);
      check(res_valid_o == e_val, {tg, " res_valid"}, res_valid_o, e_val);
      if (e_val) begin
        e_res = {16'b0, da[t-rfirst]} * {16'b0, db[t-rfirst]} + {16'b0, dc[cfirst+t-rfirst]};
        check(res_o == e_res, {tg, " result"}, res_o, e_res);
      end
      if (v == 0)
        check(done_o == (t == 0), "R6 zero-length done", done_o, (t == 0));
      else
        check(done_o == (t == last), "R5 done", done_o, (t == last));
      check(busy_o == (t <= last), "R9 busy", busy_o, (t <= last));
      if (t == last) check(cyc_o == 8'(last + 1), "R5 cycle count", cyc_o, last + 1);
      if (t == last + 2) check(cyc_o == 8'(last + 1), "R5 count hold", cyc_o, last + 1);
      // R8: inputs other than operands change freely after start
      start_i = (t == busy_at);
      vlen_i  = 7'($urandom_range(0, 127));
      chain_i = ~ch;
      a_i = 16'($urandom); b_i = 16'($urandom); c_i = 16'($urandom);
      da[t] = a_i; db[t] = b_i; dc[t] = c_i;
    end
    start_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; vlen_i = '0; chain_i = 1'b0;
    a_i = '0; b_i = '0; c_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !res_valid_o, "R1 reset flags", {busy_o, done_o, res_valid_o}, 0);
    check(!mul_take_o && !add_take_o, "R1 reset takes", {mul_take_o, add_take_o}, 0);
    check(cyc_o == 0, "R1 reset count", cyc_o, 0);

    run_op(64, 1'b1, -1);   // R3: 77 cycles
    run_op(64, 1'b0, -1);   // R4: 141 cycles
    run_op(1, 1'b1, -1);
    run_op(1, 1'b0, -1);
    run_op(0, 1'b1, -1);    // R6
    run_op(0, 1'b0, -1);    // R6
    run_op(100, 1'b1, -1);  // R7
    run_op(100, 1'b0, -1);  // R7
    run_op(20, 1'b1, 5);    // R8 start while busy
    run_op(5, 1'b0, 9);     // R8 start while busy
    run_op(13, 1'b1, -1);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 100000 cycles expected completion earlier");
    summary();
    $finish;
  end
endmodule